// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status and interrupt flags of a UART-style serial port and presents them on a simple register bus. The receiver, the transmitter and the break/sync detection logic report what happens through level inputs and one-cycle strobes. The block turns those reports into seven flags, each with its own update rule. A flag may follow a level, be cleared by writing one, be cleared by a data write, be cleared when the next byte arrives, or be a write-only trigger that reads as zero. A separate enable register masks the flags into one interrupt request.

The bus has three addresses. The status address is readable, takes write-one-to-clear and also takes the wait-for-break trigger. The enable address is read and written. A write to the transmit data address counts as loading the transmit buffer. Reads are combinational on `bus_addr`. Any other address reads as zero and ignores writes. The shift registers, data buffers and baud logic are outside the block and appear only as event inputs.

A small state machine tracks the wait for a break and the following sync character:
- `BS_IDLE`: no break pending.
- `BS_ARM`: a wait-for-break was requested.
- `BS_LOW`: the armed receive line has gone low.
- `BS_SYNC`: a break was seen and the sync character is awaited.
- `BS_FAULT`: the sync character was bad, and the machine holds until software clears the inconsistent-sync flag.

Its transitions are:
- IDLE to ARM on a wait-for-break write.
- IDLE, ARM or LOW to SYNC on the hardware break strobe.
- ARM to LOW when the synchronised line is low.
- LOW to SYNC when the line returns high.
- SYNC to IDLE on a good sync character, which sets the break-detected flag.
- SYNC to FAULT on a bad sync character, which sets the inconsistent-sync flag.
- Any state to IDLE on a write of one to the inconsistent-sync flag, unless a fault is being set in the same cycle.

Top module: `sp_status_reg`

## Requirements
- R1: After reset the status register reads 0x20, with only the data-register-empty flag (bit 5) set. The enable register reads 0x00 and `irq` is low.
- R2: Bit 7 (receive complete) equals `rx_en && rx_unread` registered one cycle. It goes low when the receiver is disabled, and a bus write cannot set it.
- R3: Bit 6 (transmit complete) sets on `tx_done` only while bit 5 is 1, meaning no transmit data is waiting. Writing 1 to bit 6 clears it.
- R4: Bit 5 (data register empty) clears on any write to the transmit data address 0x2 and sets on `tx_load`. If both happen in one cycle it clears. Status writes never change it.
- R5: Bit 4 (receive start) sets on a high-to-low transition of the synchronised `rx_line` while `standby` and `start_det_en` are both 1. It is held at 0 while `start_det_en` is 0, and writing 1 to it clears it.
- R6: Bit 3 (inconsistent sync) sets when a sync character received in BS_SYNC differs from 0x55 or arrives with `sync_tbad`. Writing 1 to it clears it and returns the state machine to BS_IDLE.
- R7: Bit 1 (break detected) sets when a sync character of 0x55 without `sync_tbad` is received in BS_SYNC. It clears on writing 1 or on `rx_data_evt`.
- R8: Writing 1 to bit 0 of the status address arms the wait-for-break sequence (BS_IDLE to BS_ARM). Bits 0 and 2 always read 0.
- R9: When a hardware set event and a write-one-to-clear (or the `rx_data_evt` auto-clear) hit the same flag in one cycle, the flag ends up set.
- R10: Writing 0 to a status bit has no effect, and writes to addresses other than 0x4, 0x5 and 0x2 change no flag.
- R11: Address 0x5 holds the enable mask; bits 0 and 2 are not stored and read 0. `irq` is high when any flag and its enable bit are both 1.
- R12: The break state machine follows the transitions listed above. A sync character received outside BS_SYNC sets neither bit 1 nor bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus address for reads and writes |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational on `bus_addr` |
| rx_en | input | 1 | Receiver enabled |
| rx_unread | input | 1 | Receive buffer holds unread data |
| rx_data_evt | input | 1 | Strobe: a data byte was received |
| rx_line | input | 1 | Raw receive line, idle high |
| standby | input | 1 | System is in standby |
| start_det_en | input | 1 | Start-condition detection enabled |
| tx_load | input | 1 | Strobe: transmit buffer moved into the shifter |
| tx_done | input | 1 | Strobe: shifter finished a frame |
| brk_evt | input | 1 | Strobe: hardware break detector fired |
| sync_rcv | input | 1 | Strobe: a sync character was received |
| sync_byte | input | 8 | Value of the received sync character |
| sync_tbad | input | 1 | Sync bit time outside the usable range |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The bench targets the same-cycle collisions:
- A transmit-complete event against its own clear. A design that lets the clear win would lose a completion interrupt.
- A good sync character against a break-flag clear or a received byte. A design that lets the clear win would lose a break report.
- A bad sync character against the inconsistent-sync clear. A design that lets the clear win would leave the state machine idle with no fault reported.
- A buffer load and a data write in the same cycle. A design that gives the load priority would report an empty buffer while data is pending.

It also sends sync characters while the machine is in BS_IDLE or BS_FAULT. A design that does not gate on BS_SYNC would raise false break or fault flags.

It drives receive-line edges with detection disabled or outside standby, to catch a receive-start flag that ignores its qualifiers. It writes all-ones to the status address, to catch a register whose hardware-owned bits the bus can set.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int FLAG_W = 8;
    localparam int B_RXC  = 7;
    localparam int B_TXC  = 6;
    localparam int B_DRE  = 5;
    localparam int B_RXS  = 4;
    localparam int B_ISF  = 3;
    localparam int B_BDF  = 1;
    localparam int B_WFB  = 0;
    localparam logic [FLAG_W-1:0] STAT_RESET = 8'h20;
    localparam logic [FLAG_W-1:0] IEN_MASK   = 8'hFA;

    typedef enum logic [2:0] {
        BS_IDLE  = 3'd0,
        BS_ARM   = 3'd1,
        BS_LOW   = 3'd2,
        BS_SYNC  = 3'd3,
        BS_FAULT = 3'd4
    } brk_st_e;
endpackage

// File: rtl/sps_bus_decode.sv
module sps_bus_decode
    import sps_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h4,
    parameter logic [ADDR_W-1:0] IEN_ADDR  = 4'h5,
    parameter logic [ADDR_W-1:0] TXD_ADDR  = 4'h2
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FLAG_W-1:0] bus_wdata,
    output logic              clr_txc,
    output logic              clr_rxs,
    output logic              clr_isf,
    output logic              clr_bdf,
    output logic              wfb_req,
    output logic              txd_wr,
    output logic              ien_wr,
    output logic              sel_stat,
    output logic              sel_ien
);
    logic stat_wr;

    always_comb begin
        sel_stat = (bus_addr == STAT_ADDR);
        sel_ien  = (bus_addr == IEN_ADDR);
        stat_wr  = bus_wr && sel_stat;
        ien_wr   = bus_wr && sel_ien;
        txd_wr   = bus_wr && (bus_addr == TXD_ADDR);
        clr_txc  = stat_wr && bus_wdata[B_TXC];
        clr_rxs  = stat_wr && bus_wdata[B_RXS];
        clr_isf  = stat_wr && bus_wdata[B_ISF];
        clr_bdf  = stat_wr && bus_wdata[B_BDF];
        wfb_req  = stat_wr && bus_wdata[B_WFB];
    end
endmodule

// File: rtl/sps_line_edge.sv
module sps_line_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b1;
                end else begin
                    chain_q[g] <= (g == 0) ? line_in : chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign line_s = chain_q[STAGES-1];
    assign fall   = prev_q && !chain_q[STAGES-1];
endmodule

// File: rtl/sps_brk_fsm.sv
module sps_brk_fsm
    import sps_pkg::*;
#(
    parameter logic [7:0] SYNC_PAT = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfb_req,
    input  logic       clr_isf,
    input  logic       brk_evt,
    input  logic       line_s,
    input  logic       sync_rcv,
    input  logic [7:0] sync_byte,
    input  logic       sync_tbad,
    output logic       bdf_set,
    output logic       isf_set,
    output brk_st_e    state
);
    brk_st_e st_q, st_d;
    logic    sync_ok;

    assign sync_ok = (sync_byte == SYNC_PAT) && !sync_tbad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BS_IDLE: begin
                if (wfb_req)      st_d = BS_ARM;
                else if (brk_evt) st_d = BS_SYNC;
            end
            BS_ARM: begin
                if (brk_evt)      st_d = BS_SYNC;
                else if (!line_s) st_d = BS_LOW;
            end
            BS_LOW: begin
                if (brk_evt || line_s) st_d = BS_SYNC;
            end
            BS_SYNC: begin
                if (sync_rcv) st_d = sync_ok ? BS_IDLE : BS_FAULT;
            end
            BS_FAULT: st_d = BS_FAULT;
            default:  st_d = BS_IDLE;
        endcase
        if (clr_isf && !isf_set) st_d = BS_IDLE;
    end

    always_comb begin
        bdf_set = 1'b0;
        isf_set = 1'b0;
        unique case (st_q)
            BS_SYNC: begin
                bdf_set = sync_rcv && sync_ok;
                isf_set = sync_rcv && !sync_ok;
            end
            BS_IDLE, BS_ARM, BS_LOW, BS_FAULT: begin
                bdf_set = 1'b0;
                isf_set = 1'b0;
            end
            default: begin
                bdf_set = 1'b0;
                isf_set = 1'b0;
            end
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/sps_flag_bank.sv
module sps_flag_bank
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_unread,
    input  logic              rx_data_evt,
    input  logic              tx_load,
    input  logic              tx_done,
    input  logic              txd_wr,
    input  logic              fall,
    input  logic              standby,
    input  logic              start_det_en,
    input  logic              clr_txc,
    input  logic              clr_rxs,
    input  logic              clr_isf,
    input  logic              clr_bdf,
    input  logic              isf_set,
    input  logic              bdf_set,
    output logic [FLAG_W-1:0] flags
);
    logic rxc_q, txc_q, dre_q, rxs_q, isf_q, bdf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxc_q <= STAT_RESET[B_RXC];
            txc_q <= STAT_RESET[B_TXC];
            dre_q <= STAT_RESET[B_DRE];
            rxs_q <= STAT_RESET[B_RXS];
            isf_q <= STAT_RESET[B_ISF];
            bdf_q <= STAT_RESET[B_BDF];
        end else begin
            rxc_q <= rx_en && rx_unread;

            if (tx_done && dre_q) txc_q <= 1'b1;
            else if (clr_txc)     txc_q <= 1'b0;

            if (txd_wr)       dre_q <= 1'b0;
            else if (tx_load) dre_q <= 1'b1;

            if (!start_det_en)        rxs_q <= 1'b0;
            else if (fall && standby) rxs_q <= 1'b1;
            else if (clr_rxs)         rxs_q <= 1'b0;

            if (isf_set)      isf_q <= 1'b1;
            else if (clr_isf) isf_q <= 1'b0;

            if (bdf_set)                     bdf_q <= 1'b1;
            else if (clr_bdf || rx_data_evt) bdf_q <= 1'b0;
        end
    end

    assign flags = {rxc_q, txc_q, dre_q, rxs_q, isf_q, 1'b0, bdf_q, 1'b0};
endmodule

// File: rtl/sp_status_reg.sv
module sp_status_reg
    import sps_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h4,
    parameter logic [ADDR_W-1:0] IEN_ADDR  = 4'h5,
    parameter logic [ADDR_W-1:0] TXD_ADDR  = 4'h2,
    parameter int SYNC_STAGES = 2,
    parameter logic [7:0] SYNC_PAT = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_en,
    input  logic              rx_unread,
    input  logic              rx_data_evt,
    input  logic              rx_line,
    input  logic              standby,
    input  logic              start_det_en,
    input  logic              tx_load,
    input  logic              tx_done,
    input  logic              brk_evt,
    input  logic              sync_rcv,
    input  logic [7:0]        sync_byte,
    input  logic              sync_tbad,
    output logic              irq
);
    logic clr_txc, clr_rxs, clr_isf, clr_bdf, wfb_req;
    logic txd_wr, ien_wr, sel_stat, sel_ien;
    logic line_s, fall, bdf_set, isf_set;
    logic [FLAG_W-1:0] flags_w;
    logic [FLAG_W-1:0] ien_q;
    brk_st_e brk_st;

    sps_bus_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
        .IEN_ADDR(IEN_ADDR), .TXD_ADDR(TXD_ADDR)
    ) dec_i (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .clr_txc(clr_txc), .clr_rxs(clr_rxs), .clr_isf(clr_isf),
        .clr_bdf(clr_bdf), .wfb_req(wfb_req), .txd_wr(txd_wr),
        .ien_wr(ien_wr), .sel_stat(sel_stat), .sel_ien(sel_ien)
    );

    sps_line_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line),
        .line_s(line_s), .fall(fall)
    );

    sps_brk_fsm #(.SYNC_PAT(SYNC_PAT)) fsm_i (
        .clk(clk), .rst_n(rst_n), .wfb_req(wfb_req), .clr_isf(clr_isf),
        .brk_evt(brk_evt), .line_s(line_s), .sync_rcv(sync_rcv),
        .sync_byte(sync_byte), .sync_tbad(sync_tbad),
        .bdf_set(bdf_set), .isf_set(isf_set), .state(brk_st)
    );

    sps_flag_bank flags_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_unread(rx_unread),
        .rx_data_evt(rx_data_evt), .tx_load(tx_load), .tx_done(tx_done),
        .txd_wr(txd_wr), .fall(fall), .standby(standby),
        .start_det_en(start_det_en), .clr_txc(clr_txc), .clr_rxs(clr_rxs),
        .clr_isf(clr_isf), .clr_bdf(clr_bdf), .isf_set(isf_set),
        .bdf_set(bdf_set), .flags(flags_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (ien_wr) begin
            ien_q <= bus_wdata & IEN_MASK;
        end
    end

    always_comb begin
        if (sel_stat)     bus_rdata = flags_w;
        else if (sel_ien) bus_rdata = ien_q;
        else              bus_rdata = '0;
    end

    assign irq = |(flags_w & ien_q);
endmodule

// File: rtl/sps_chk.sv
module sps_chk
    import sps_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h4,
    parameter logic [ADDR_W-1:0] TXD_ADDR  = 4'h2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              rx_en,
    input logic              rx_unread,
    input logic              rx_data_evt,
    input logic              start_det_en,
    input logic              tx_done,
    input logic              sync_rcv,
    input brk_st_e           st,
    input logic [7:0]        flags
);
    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> flags == STAT_RESET);

    // R2
    rxc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flags[B_RXC] == $past(rx_en && rx_unread));

    // R3
    txc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && flags[B_DRE]) |=> flags[B_TXC]);

    // R4
    dre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == TXD_ADDR) |=> !flags[B_DRE]);

    // R5
    rxs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_det_en |=> !flags[B_RXS]);

    // R6
    isf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_ADDR && bus_wdata[B_ISF]
         && !(st == BS_SYNC && sync_rcv)) |=> st == BS_IDLE);

    // R7
    bdf_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data_evt && st != BS_SYNC) |=> !flags[B_BDF]);

    // R8
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[B_WFB] && !flags[2]);

    // R12
    fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == BS_FAULT |-> flags[B_ISF]);
endmodule

bind sp_status_reg sps_chk #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .TXD_ADDR(TXD_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rx_en(rx_en), .rx_unread(rx_unread),
    .rx_data_evt(rx_data_evt), .start_det_en(start_det_en),
    .tx_done(tx_done), .sync_rcv(sync_rcv), .st(brk_st), .flags(flags_w)
);

// File: tb/sp_status_reg_tb_top.sv
module sp_status_reg_tb_top;
    localparam logic [3:0] STAT = 4'h4;
    localparam logic [3:0] IEN  = 4'h5;
    localparam logic [3:0] TXD  = 4'h2;
    localparam int NVEC = 13;
    // {wr, addr[3:0], wdata[7:0], tx_load, tx_done, expected status[7:0]}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 4'h0, 8'h00, 1'b0, 1'b1, 8'h60}, // R3 set while buffer empty
        {1'b1, STAT, 8'h40, 1'b0, 1'b0, 8'h20}, // R3 w1c
        {1'b1, TXD,  8'hA5, 1'b0, 1'b0, 8'h00}, // R4 data write clears
        {1'b0, 4'h0, 8'h00, 1'b0, 1'b1, 8'h00}, // R3 no set while data waits
        {1'b1, STAT, 8'hFF, 1'b0, 1'b0, 8'h00}, // R4 R2 R8 bus cannot set
        {1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 8'h20}, // R4 load sets
        {1'b0, 4'h0, 8'h00, 1'b0, 1'b1, 8'h60}, // R3
        {1'b1, STAT, 8'h40, 1'b0, 1'b1, 8'h60}, // R9 set beats clear
        {1'b1, STAT, 8'h00, 1'b0, 1'b0, 8'h60}, // R10 zero write
        {1'b1, 4'h7, 8'hFF, 1'b0, 1'b0, 8'h60}, // R10 other address
        {1'b1, STAT, 8'h40, 1'b0, 1'b0, 8'h20}, // R3
        {1'b1, TXD,  8'h11, 1'b1, 1'b0, 8'h00}, // R4 write beats load
        {1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 8'h20}  // R4
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [3:0] bus_addr = STAT;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic rx_en = 1'b0, rx_unread = 1'b0, rx_data_evt = 1'b0, rx_line = 1'b1;
    logic standby = 1'b0, start_det_en = 1'b0, tx_load = 1'b0, tx_done = 1'b0;
    logic brk_evt = 1'b0, sync_rcv = 1'b0, sync_tbad = 1'b0;
    logic [7:0] sync_byte = '0;
    logic irq;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] got;

    always #5 clk = ~clk;

    sp_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_en(rx_en),
        .rx_unread(rx_unread), .rx_data_evt(rx_data_evt), .rx_line(rx_line),
        .standby(standby), .start_det_en(start_det_en), .tx_load(tx_load),
        .tx_done(tx_done), .brk_evt(brk_evt), .sync_rcv(sync_rcv),
        .sync_byte(sync_byte), .sync_tbad(sync_tbad), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = STAT;
    endtask

    task automatic brk();
        brk_evt = 1'b1;
        tick();
        brk_evt = 1'b0;
    endtask

    task automatic sync(input logic [7:0] b, input logic bad);
        sync_rcv = 1'b1; sync_byte = b; sync_tbad = bad;
        tick();
        sync_rcv = 1'b0; sync_tbad = 1'b0;
    endtask

    task automatic line_to(input logic v);
        rx_line = v;
        repeat (4) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(STAT, got); chk("R1 status reset", got, 8'h20);
        rd(IEN, got);  chk("R1 enable reset", got, 8'h00);
        chk("R1 irq reset", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            bus_wr = VEC[i][22]; bus_addr = VEC[i][21:18];
            bus_wdata = VEC[i][17:10]; tx_load = VEC[i][9]; tx_done = VEC[i][8];
            tick();
            bus_wr = 1'b0; tx_load = 1'b0; tx_done = 1'b0;
            rd(STAT, got); chk($sformatf("R3/R4/R9/R10 vector %0d", i), got, VEC[i][7:0]);
        end

        // R2
        rx_en = 1'b1; rx_unread = 1'b1; tick();
        rd(STAT, got); chk("R2 unread data", got, 8'hA0);
        rx_en = 1'b0; tick();
        rd(STAT, got); chk("R2 receiver disabled", got, 8'h20);
        rx_en = 1'b1; rx_unread = 1'b0; wr(STAT, 8'h80);
        rd(STAT, got); chk("R2 bus write ignored", got, 8'h20);

        // R5
        start_det_en = 1'b1; standby = 1'b1; line_to(1'b0);
        rd(STAT, got); chk("R5 start detected", got, 8'h30);
        wr(STAT, 8'h10);
        rd(STAT, got); chk("R5 w1c", got, 8'h20);
        line_to(1'b1); line_to(1'b0);
        rd(STAT, got); chk("R5 second start", got, 8'h30);
        start_det_en = 1'b0; tick();
        rd(STAT, got); chk("R5 disable clears", got, 8'h20);
        line_to(1'b1); line_to(1'b0);
        rd(STAT, got); chk("R5 edge while disabled", got, 8'h20);
        line_to(1'b1); standby = 1'b0; start_det_en = 1'b1; line_to(1'b0);
        rd(STAT, got); chk("R5 edge outside standby", got, 8'h20);
        line_to(1'b1); start_det_en = 1'b0;

        // R7 R12
        brk(); sync(8'h55, 1'b0);
        rd(STAT, got); chk("R7 good sync", got, 8'h22);
        rx_data_evt = 1'b1; tick(); rx_data_evt = 1'b0;
        rd(STAT, got); chk("R7 auto clear", got, 8'h20);
        brk(); sync(8'h55, 1'b0); wr(STAT, 8'h02);
        rd(STAT, got); chk("R7 w1c", got, 8'h20);

        // R9
        brk();
        bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 8'h02;
        sync(8'h55, 1'b0); bus_wr = 1'b0;
        rd(STAT, got); chk("R9 break set beats w1c", got, 8'h22);
        brk(); rx_data_evt = 1'b1; sync(8'h55, 1'b0); rx_data_evt = 1'b0;
        rd(STAT, got); chk("R9 break set beats auto clear", got, 8'h22);
        wr(STAT, 8'h02);

        // R6 R12
        brk(); sync(8'h54, 1'b0);
        rd(STAT, got); chk("R6 bad sync", got, 8'h28);
        sync(8'h55, 1'b0);
        rd(STAT, got); chk("R12 sync ignored in fault", got, 8'h28);
        wr(STAT, 8'h08);
        rd(STAT, got); chk("R6 w1c", got, 8'h20);
        sync(8'h55, 1'b0);
        rd(STAT, got); chk("R12 sync ignored in idle", got, 8'h20);
        brk(); sync(8'h55, 1'b1);
        rd(STAT, got); chk("R6 bad bit time", got, 8'h28);
        wr(STAT, 8'h08);
        brk();
        bus_wr = 1'b1; bus_addr = STAT; bus_wdata = 8'h08;
        sync(8'h33, 1'b0); bus_wr = 1'b0;
        rd(STAT, got); chk("R9 fault set beats w1c", got, 8'h28);
        wr(STAT, 8'h08);
        rd(STAT, got); chk("R6 cleared again", got, 8'h20);

        // R8
        wr(STAT, 8'h01);
        rd(STAT, got); chk("R8 trigger reads zero", got, 8'h20);
        line_to(1'b0); line_to(1'b1); sync(8'h55, 1'b0);
        rd(STAT, got); chk("R8 armed break then sync", got, 8'h22);
        wr(STAT, 8'h02);
        line_to(1'b0); line_to(1'b1); sync(8'h55, 1'b0);
        rd(STAT, got); chk("R12 pulse without arming", got, 8'h20);

        // R11
        wr(IEN, 8'hFF);
        rd(IEN, got); chk("R11 enable mask", got, 8'hFA);
        chk("R11 irq from empty flag", {7'b0, irq}, 8'h01);
        wr(IEN, 8'h02);
        chk("R11 irq masked", {7'b0, irq}, 8'h00);
        brk(); sync(8'h55, 1'b0);
        chk("R11 irq from break", {7'b0, irq}, 8'h01);
        wr(IEN, 8'h00);
        chk("R11 irq disabled", {7'b0, irq}, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule